// File: doc/BRIEF.md
# Reflected CRC-32 Checksum Engine

This block keeps a running 32-bit cyclic redundancy check over a stream of bytes. It uses the standard 32-bit generator in its bit-reversed form, so the register shifts right and each byte enters least significant bit first. Each byte is XORed into the low eight bits of the register, and then eight shift steps run. Each step shifts right by one and XORs in the reversed polynomial when the bit that leaves the register is one. The raw register value is the result, with no final inversion.

One byte is absorbed on every cycle where the valid strobe is high. The eight bit-steps are unrolled into a combinational chain. A start pulse presets the register at the beginning of a message. If the pulse comes in the same cycle as a byte, that byte is folded into the fresh preset value. Every data bit passes through the feedback decision, so the last bytes of a message affect the result as much as the first ones.

A small controller tracks the message state. ST_EMPTY means the register holds the preset and no byte has been absorbed. ST_ACCUM means at least one byte has been folded in.

The transitions are as follows:
- Reset moves to ST_EMPTY.
- A valid byte moves from ST_EMPTY or ST_ACCUM to ST_ACCUM.
- A start pulse without a byte moves to ST_EMPTY.
- A cycle with neither start nor valid keeps the current state.

Top module: `crc32_reflect_engine`

## Requirements
- R1: A synchronous active-high reset sets the result to 0xFFFFFFFF on the next clock edge.
- R2: A start pulse with valid low reloads the result to 0xFFFFFFFF on the next clock edge.
- R3: When start and valid are both low, the result does not change, whatever value is on the data input.
- R4: On a valid cycle the new result is computed in two stages. First the byte is XORed into register bits 7:0. Then eight steps run, and each step is: if bit 0 is 1, shift right by one and XOR with 0xEDB88320; otherwise shift right by one. This means data bit 0 is consumed first.
- R5: When start and valid are high in the same cycle, the byte is processed against 0xFFFFFFFF instead of the old register value.
- R6: No final XOR is applied. The result is the register after the last byte. For the ASCII string "123456789" the result is 0x340BC6D9.
- R7: A message with no bytes after start reads 0xFFFFFFFF. While the controller is in ST_EMPTY, the result equals the preset.
- R8: Every bit of the final byte steers the feedback. Flipping any one bit of the last byte changes the result in more than one bit position. The new result matches the bit-serial definition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start of message; presets the register |
| valid_i | input | 1 | data_i holds a byte to absorb this cycle |
| data_i | input | 8 | Message byte, least significant bit consumed first |
| crc_o | output | 32 | Current register value, the checksum |

## Verification
Two situations are the hardest to reach from the ports. The first is a start pulse that lands in the same cycle as a data byte. The second is idle gaps inside a message, while the data input carries random noise. The stimulus sends random-length messages in which the first byte often shares its cycle with start, and random idle cycles with random data are placed between bytes. Sensitivity to the final byte is tested by resending one message eight times, each time with one bit of the last byte flipped. The exhaustive sweep covers all 256 single-byte messages.

// File: rtl/crc32_pkg.sv
package crc32_pkg;
    localparam int          CRC_W      = 32;
    localparam int          DATA_W     = 8;
    localparam logic [31:0] POLY_REFL  = 32'hEDB88320;
    localparam logic [31:0] PRESET_VAL = 32'hFFFFFFFF;

    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_ACCUM = 1'b1
    } crc_state_e;
endpackage

// File: rtl/crc_bit_step.sv
module crc_bit_step #(
    parameter int               W    = 32,
    parameter logic [W-1:0]     POLY = 32'hEDB88320
) (
    input  logic [W-1:0] reg_i,
    output logic [W-1:0] reg_o
);
    always_comb begin
        if (reg_i[0]) begin
            reg_o = (reg_i >> 1) ^ POLY;
        end else begin
            reg_o = reg_i >> 1;
        end
    end
endmodule

// File: rtl/crc_byte_update.sv
module crc_byte_update #(
    parameter int           W    = 32,
    parameter int           DW   = 8,
    parameter logic [W-1:0] POLY = 32'hEDB88320
) (
    input  logic [W-1:0]  crc_i,
    input  logic [DW-1:0] byte_i,
    output logic [W-1:0]  crc_o
);
    localparam int PAD_W = W - DW;

    logic [W-1:0] stage [0:DW];

    assign stage[0] = crc_i ^ {{PAD_W{1'b0}}, byte_i};

    for (genvar g = 0; g < DW; g++) begin : g_step
        crc_bit_step #(.W(W), .POLY(POLY)) u_step (
            .reg_i (stage[g]),
            .reg_o (stage[g+1])
        );
    end

    assign crc_o = stage[DW];
endmodule

// File: rtl/crc_seq_ctrl.sv
module crc_seq_ctrl
    import crc32_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       valid_i,
    output crc_state_e state_o,
    output logic       use_preset_o,
    output logic       capture_o,
    output logic       clear_o
);
    crc_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d      = state_q;
        use_preset_o = start_i;
        capture_o    = valid_i;
        clear_o      = start_i & ~valid_i;
        unique case (state_q)
            ST_EMPTY: begin
                if (valid_i) state_d = ST_ACCUM;
                else         state_d = ST_EMPTY;
            end
            ST_ACCUM: begin
                if (valid_i)      state_d = ST_ACCUM;
                else if (start_i) state_d = ST_EMPTY;
                else              state_d = ST_ACCUM;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/crc32_reflect_engine.sv
module crc32_reflect_engine
    import crc32_pkg::*;
#(
    parameter int               CRC_BITS  = CRC_W,
    parameter int               BYTE_BITS = DATA_W,
    parameter logic [CRC_W-1:0] POLY      = POLY_REFL,
    parameter logic [CRC_W-1:0] PRESET    = PRESET_VAL
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic                 valid_i,
    input  logic [BYTE_BITS-1:0] data_i,
    output logic [CRC_BITS-1:0]  crc_o
);
    crc_state_e          state;
    logic                use_preset;
    logic                capture;
    logic                clear;
    logic [CRC_BITS-1:0] crc_q;
    logic [CRC_BITS-1:0] base;
    logic [CRC_BITS-1:0] updated;

    crc_seq_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .valid_i      (valid_i),
        .state_o      (state),
        .use_preset_o (use_preset),
        .capture_o    (capture),
        .clear_o      (clear)
    );

    assign base = use_preset ? PRESET[CRC_BITS-1:0] : crc_q;

    crc_byte_update #(.W(CRC_BITS), .DW(BYTE_BITS), .POLY(POLY[CRC_BITS-1:0])) u_upd (
        .crc_i  (base),
        .byte_i (data_i),
        .crc_o  (updated)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= PRESET[CRC_BITS-1:0];
        end else if (capture) begin
            crc_q <= updated;
        end else if (clear) begin
            crc_q <= PRESET[CRC_BITS-1:0];
        end
    end

    assign crc_o = crc_q;

    assert_reset_preset_R1: assert property (@(posedge clk)
        $past(rst) |-> crc_q == PRESET[CRC_BITS-1:0]);

    assert_start_reload_R2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !valid_i) |=> crc_o == PRESET[CRC_BITS-1:0]);

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !valid_i) |=> $stable(crc_o));

    assert_empty_is_preset_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EMPTY) |-> crc_o == PRESET[CRC_BITS-1:0]);
endmodule

// File: tb/tb_crc32_reflect_engine.sv
module tb_crc32_reflect_engine;
    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic        valid_i;
    logic [7:0]  data_i;
    logic [31:0] crc_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] msg [0:31];

    always #10 clk = ~clk;

    crc32_reflect_engine dut (
        .clk(clk), .rst(rst), .start_i(start_i), .valid_i(valid_i),
        .data_i(data_i), .crc_o(crc_o)
    );

    function automatic logic [31:0] ref_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ b[i]) r = (r >> 1) ^ 32'hEDB88320;
            else             r = r >> 1;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic drive(input logic s, input logic v, input logic [7:0] d);
        @(negedge clk);
        start_i = s; valid_i = v; data_i = d;
        @(posedge clk);
    endtask

    task automatic settle();
        @(negedge clk);
        start_i = 1'b0; valid_i = 1'b0; data_i = 8'($urandom);
    endtask

    task automatic send_msg(input int len, input bit merge_start, input bit gaps,
                            output logic [31:0] expv);
        logic [31:0] r;
        r = 32'hFFFFFFFF;
        if (!(merge_start && len > 0)) drive(1'b1, 1'b0, 8'($urandom));
        for (int i = 0; i < len; i++) begin
            if (gaps && i > 0 && ($urandom_range(0, 2) == 0))
                drive(1'b0, 1'b0, 8'($urandom));
            drive((merge_start && i == 0), 1'b1, msg[i]);
            r = ref_byte(r, msg[i]);
        end
        settle();
        expv = r;
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        report();
    end

    initial begin
        logic [31:0] e, base_res, flip_res, noise_hold;
        rst = 1'b1; start_i = 1'b0; valid_i = 1'b0; data_i = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        check("R1 reset preset", crc_o, 32'hFFFFFFFF);

        // R6: check string, with and without start merged into first byte
        for (int i = 0; i < 9; i++) msg[i] = 8'h31 + 8'(i);
        send_msg(9, 1'b0, 1'b0, e);
        check("R6 check string", crc_o, 32'h340BC6D9);
        check("R4 check string model", crc_o, e);
        send_msg(9, 1'b1, 1'b1, e);
        check("R5 check string merged start", crc_o, 32'h340BC6D9);

        // R3: idle cycles with noisy data do not change the result
        noise_hold = crc_o;
        for (int i = 0; i < 5; i++) drive(1'b0, 1'b0, 8'($urandom));
        settle();
        check("R3 idle hold", crc_o, noise_hold);

        // R2: start alone reloads the preset; R7: empty message
        drive(1'b1, 1'b0, 8'hA5);
        settle();
        check("R2 start reload", crc_o, 32'hFFFFFFFF);
        send_msg(0, 1'b0, 1'b0, e);
        check("R7 empty message", crc_o, 32'hFFFFFFFF);

        // R4: exhaustive single-byte sweep from preset
        for (int b = 0; b < 256; b++) begin
            msg[0] = 8'(b);
            send_msg(1, b[0], 1'b0, e);
            check($sformatf("R4 single byte %02h", b), crc_o, e);
        end

        // R5: start in same cycle as first byte, after a non-preset history
        for (int t = 0; t < 20; t++) begin
            msg[0] = 8'($urandom); msg[1] = 8'($urandom);
            send_msg(2, 1'b0, 1'b0, e);
            msg[0] = 8'($urandom);
            send_msg(1, 1'b1, 1'b0, e);
            check("R5 merged start", crc_o, ref_byte(32'hFFFFFFFF, msg[0]));
        end

        // Random-length messages with gaps (R4, R3, R5)
        for (int t = 0; t < 60; t++) begin
            int len;
            len = $urandom_range(0, 24);
            for (int i = 0; i < len; i++) msg[i] = 8'($urandom);
            send_msg(len, 1'($urandom), 1'b1, e);
            check($sformatf("R4 random message len %0d", len), crc_o, e);
        end

        // R8: each bit of the final byte steers feedback
        for (int i = 0; i < 4; i++) msg[i] = 8'($urandom);
        send_msg(4, 1'b0, 1'b0, base_res);
        check("R8 base message", crc_o, base_res);
        for (int k = 0; k < 8; k++) begin
            msg[3] = msg[3] ^ (8'h01 << k);
            send_msg(4, 1'b0, 1'b0, e);
            flip_res = crc_o;
            check($sformatf("R8 flipped bit %0d model", k), flip_res, e);
            checks++;
            if ($countones(flip_res ^ base_res) <= 1) begin
                errors++;
                $display("FAIL R8 bit %0d: actual diff %08h expected more than one bit",
                         k, flip_res ^ base_res);
            end
            msg[3] = msg[3] ^ (8'h01 << k);
        end

        // R1: reset in the middle of a message
        drive(1'b1, 1'b1, 8'h5A);
        drive(1'b0, 1'b1, 8'h3C);
        @(negedge clk); rst = 1'b1; valid_i = 1'b1;
        @(posedge clk);
        @(negedge clk); rst = 1'b0; valid_i = 1'b0;
        check("R1 mid-message reset", crc_o, 32'hFFFFFFFF);

        report();
    end
endmodule